// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives a slower clock from a single reference clock. Software writes a control register whose divider field gives the division ratio. Synthesis-time parameters fix four things: the field's position and width, the rule that turns the field into a divisor, the allowed divisor range, and the register positions of the idle-enable and commit bits. Four decoding rules are available. The divisor can be the field plus one, the field itself, two raised to the field, or an entry of a parameter table in which a zero entry marks an unusable code.

A write whose field decodes to an unusable divisor is dropped as a whole, and a sticky error output is raised. When commit mode is built in, a write only stages the field. The counter takes the new ratio only from a write that also carries the commit bit. A new ratio is applied at the end of the current output period, so no high or low phase is ever cut short. An idle-enable bit, whose active level is a parameter, lets an external idle request park the output low at the next period boundary.

Top module: `regdiv_clkgen`

## Requirements
- R1: With the plus-one rule, field code c divides by c+1, so code 0 gives the reference clock unchanged.
- R2: With the direct rule, field code c divides by c, and code 0 is rejected.
- R3: With the power-of-two rule, field code c divides by 2^c (codes 0, 1, 2, 3 give 1, 2, 4, 8).
- R4: With the table rule, field code c divides by table entry c (entry c in bits [8c+7:8c] of the table parameter), and a code whose entry is zero is rejected.
- R5: Outside the table rule, a decoded divisor below MIN_DIV or above MAX_DIV is rejected.
- R6: A rejected write leaves the register readback and the output period unchanged, and sets div_err, which then stays high until reset.
- R7: For a divisor N of 2 or more, each output period is N reference cycles, with floor(N/2) cycles high followed by ceil(N/2) cycles low. For N = 1, clk_div follows clk_ref.
- R8: After the divisor changes, every output high and low phase has the full length of either the old or the new divisor.
- R9: With LATCH_EN set, a write without the commit bit (bit LATCH_BIT) updates the readback but not the output period. A write with that bit set commits its own field.
- R10: Idle parking is enabled when the bit at IDLE_BIT differs from IDLE_INV. While parking is enabled and idle_req is high, clk_div is held low from the end of the current period. Dividing resumes once parking is no longer requested.
- R11: Readback returns the stored field at bit offset DIV_SHIFT and the idle-enable bit at IDLE_BIT. All other bits, including the commit bit, read zero.
- R12: After reset, the field reads RST_CODE, the divisor is the decoded RST_CODE, and div_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | CTRL_W | Control register write data |
| reg_rdata | output | CTRL_W | Control register readback |
| idle_req | input | 1 | External request to park the output |
| clk_div | output | 1 | Divided clock |
| div_err | output | 1 | Sticky flag for a rejected write |

## Verification
The bench builds four copies of the block, one for each decoding rule, and each copy uses a different field offset, field width and bound set. The plus-one copy has its maximum at 127, so the top code overflows the bound, and changes at random phases show that no phase is shortened. The direct copy sits at offset 24 with a minimum of 2 and commit mode enabled, which covers staging before commit and rejection of codes 0 and 1. The power-of-two copy starts in pass-through and caps at 64. The table copy holds zero entries and an odd divisor, and has its idle-enable polarity inverted, so parking is active straight out of reset.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Rule used to turn the register field into a division ratio.
  typedef enum logic [1:0] {
    ENC_PLUS1  = 2'd0,
    ENC_DIRECT = 2'd1,
    ENC_POW2   = 2'd2,
    ENC_TABLE  = 2'd3
  } div_enc_e;

endpackage

// File: rtl/clkdiv_rstsync.sv
`timescale 1ns/1ps
module clkdiv_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_n;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_decode.sv
`timescale 1ns/1ps
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter div_enc_e    ENC       = ENC_PLUS1,
  parameter int unsigned DIV_W     = 7,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 127,
  parameter int unsigned TBL_N     = 16,
  parameter int unsigned TBL_EW    = 8,
  parameter logic [TBL_N*TBL_EW-1:0] DIV_TABLE = '0,
  parameter int unsigned DV_W      = 8
) (
  input  logic [DIV_W-1:0] code,
  output logic [DV_W-1:0]  div,
  output logic             ok
);

  localparam logic [31:0] DV_MAX = (32'd1 << DV_W) - 32'd1;

  logic [31:0] wide;

  // One decoding rule per build.
  generate
    if (ENC == ENC_PLUS1) begin : g_plus1
      assign wide = 32'(code) + 32'd1;
    end else if (ENC == ENC_DIRECT) begin : g_direct
      assign wide = 32'(code);
    end else if (ENC == ENC_POW2) begin : g_pow2
      always_comb begin
        wide = (32'(code) < 32'd31) ? (32'd1 << code) : 32'd0;
      end
    end else begin : g_table
      always_comb begin
        wide = '0;
        for (int i = 0; i < TBL_N; i++) begin
          if (32'(code) == 32'(i)) begin
            wide = 32'(DIV_TABLE[i*TBL_EW +: TBL_EW]);
          end
        end
      end
    end
  endgenerate

  generate
    if (ENC == ENC_TABLE) begin : g_ok_tbl
      assign ok = (wide != 32'd0) && (wide <= DV_MAX);
    end else begin : g_ok_rng
      assign ok = (wide != 32'd0) && (wide >= 32'(MIN_DIV)) && (wide <= 32'(MAX_DIV));
    end
  endgenerate

  assign div = wide[DV_W-1:0];

endmodule

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter div_enc_e    ENC       = ENC_PLUS1,
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned DIV_W     = 7,
  parameter int unsigned DIV_SHIFT = 0,
  parameter int unsigned IDLE_BIT  = 8,
  parameter int unsigned LATCH_BIT = 9,
  parameter bit          LATCH_EN  = 1'b0,
  parameter bit          IDLE_INV  = 1'b0,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 127,
  parameter int unsigned RST_CODE  = 0,
  parameter int unsigned TBL_N     = 16,
  parameter int unsigned TBL_EW    = 8,
  parameter logic [TBL_N*TBL_EW-1:0] DIV_TABLE = '0,
  parameter int unsigned DV_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [DV_W-1:0]   pend_div,
  output logic [DV_W-1:0]   rst_div,
  output logic              aidle_en,
  output logic              err
);

  localparam logic [DIV_W-1:0] RST_FLD = DIV_W'(RST_CODE);

  logic [DIV_W-1:0] wr_fld;
  logic [DV_W-1:0]  wr_div;
  logic             wr_ok;
  logic [DV_W-1:0]  rst_dec;
  logic             rst_ok;
  logic             commit;
  logic             unused_wdata;

  logic [DIV_W-1:0] fld_q,   fld_n;
  logic             aidle_q, aidle_n;
  logic [DV_W-1:0]  pend_q,  pend_n;
  logic             err_q,   err_n;

  assign wr_fld       = wdata[DIV_SHIFT +: DIV_W];
  assign unused_wdata = ^wdata;

  clkdiv_decode #(
    .ENC(ENC), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .TBL_N(TBL_N), .TBL_EW(TBL_EW), .DIV_TABLE(DIV_TABLE), .DV_W(DV_W)
  ) u_wdec (
    .code (wr_fld),
    .div  (wr_div),
    .ok   (wr_ok)
  );

  clkdiv_decode #(
    .ENC(ENC), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .TBL_N(TBL_N), .TBL_EW(TBL_EW), .DIV_TABLE(DIV_TABLE), .DV_W(DV_W)
  ) u_rdec (
    .code (RST_FLD),
    .div  (rst_dec),
    .ok   (rst_ok)
  );

  // Unusable reset code falls back to pass-through.
  assign rst_div = rst_ok ? rst_dec : DV_W'(1);

  generate
    if (LATCH_EN) begin : g_latch
      assign commit = wdata[LATCH_BIT];
    end else begin : g_direct
      assign commit = 1'b1;
    end
  endgenerate

  always_comb begin
    fld_n   = fld_q;
    aidle_n = aidle_q;
    pend_n  = pend_q;
    err_n   = err_q;
    if (wr_ok) begin
      fld_n   = wr_fld;
      aidle_n = wdata[IDLE_BIT];
      if (commit) begin
        pend_n = wr_div;
      end
    end else begin
      err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q   <= RST_FLD;
      aidle_q <= 1'b0;
      pend_q  <= rst_div;
      err_q   <= 1'b0;
    end else if (we) begin
      fld_q   <= fld_n;
      aidle_q <= aidle_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
    end
  end

  always_comb begin
    rdata                      = '0;
    rdata[DIV_SHIFT +: DIV_W]  = fld_q;
    rdata[IDLE_BIT]            = aidle_q;
  end

  assign pend_div = pend_q;
  assign aidle_en = aidle_q ^ IDLE_INV;
  assign err      = err_q;

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_ok) |=> ($stable(fld_q) && $stable(pend_q) && err_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R6
  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCH_EN && we && !wdata[LATCH_BIT]) |=> $stable(pend_q)); // R9
  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) && ((ENC == ENC_TABLE) ||
     ((32'(pend_q) >= 32'(MIN_DIV)) && (32'(pend_q) <= 32'(MAX_DIV))))); // R5

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int unsigned DV_W = 8
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic [DV_W-1:0] pend_div,
  input  logic [DV_W-1:0] rst_div,
  input  logic            aidle_en,
  input  logic            idle_req,
  output logic            clk_div
);

  logic [DV_W-1:0] cnt_q, cnt_n;
  logic [DV_W-1:0] cur_q, cur_n;
  logic            held_q, held_n;
  logic            out_q, out_n;
  logic            wrap;
  logic            idle_act;

  assign idle_act = aidle_en && idle_req;
  assign wrap     = held_q || (cnt_q == (cur_q - DV_W'(1)));

  // Period boundary: pick up staged ratio and idle decision.
  always_comb begin
    if (wrap) begin
      cur_n  = pend_div;
      held_n = idle_act;
      cnt_n  = '0;
    end else begin
      cur_n  = cur_q;
      held_n = held_q;
      cnt_n  = cnt_q + DV_W'(1);
    end
    out_n = !held_n && (cnt_n < (cur_n >> 1));
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cur_q  <= rst_div;
      held_q <= 1'b0;
      out_q  <= (rst_div > DV_W'(1));
    end else begin
      cnt_q <= cnt_n;
      out_q <= out_n;
      if (wrap) begin
        cur_q  <= cur_n;
        held_q <= held_n;
      end
    end
  end

  // Ratio one bypasses the register stage.
  assign clk_div = ((cur_q == DV_W'(1)) && !held_q) ? clk_ref : out_q;

  AST_CNT_BELOW_DIV: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt_q < cur_q); // R7
  AST_FALL_AT_HALF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(out_q) |-> (cnt_q == (cur_q >> 1))); // R7
  AST_RISE_AT_START: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(out_q) |-> ((cnt_q == '0) && !held_q)); // R8
  AST_PARK_ENTER: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (wrap && idle_act) |=> (held_q && !out_q)); // R10
  AST_PARKED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    held_q |-> !clk_div); // R10

endmodule

// File: rtl/regdiv_clkgen.sv
`timescale 1ns/1ps
module regdiv_clkgen
  import clkdiv_pkg::*;
#(
  parameter div_enc_e    ENC       = ENC_PLUS1,
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned DIV_W     = 7,
  parameter int unsigned DIV_SHIFT = 0,
  parameter int unsigned IDLE_BIT  = 8,
  parameter int unsigned LATCH_BIT = 9,
  parameter bit          LATCH_EN  = 1'b0,
  parameter bit          IDLE_INV  = 1'b0,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 127,
  parameter int unsigned RST_CODE  = 0,
  parameter int unsigned TBL_N     = 16,
  parameter int unsigned TBL_EW    = 8,
  parameter logic [TBL_N*TBL_EW-1:0] DIV_TABLE = '0
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              idle_req,
  output logic              clk_div,
  output logic              div_err
);

  localparam int unsigned RNG_W = $clog2(MAX_DIV + 1);
  localparam int unsigned DV_W  = (RNG_W > TBL_EW) ? RNG_W : TBL_EW;

  logic            rst_n_s;
  logic [DV_W-1:0] pend_div;
  logic [DV_W-1:0] rst_div;
  logic            aidle_en;

  clkdiv_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk_ref),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  clkdiv_regs #(
    .ENC(ENC), .CTRL_W(CTRL_W), .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT),
    .IDLE_BIT(IDLE_BIT), .LATCH_BIT(LATCH_BIT), .LATCH_EN(LATCH_EN),
    .IDLE_INV(IDLE_INV), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .RST_CODE(RST_CODE), .TBL_N(TBL_N), .TBL_EW(TBL_EW),
    .DIV_TABLE(DIV_TABLE), .DV_W(DV_W)
  ) u_regs (
    .clk      (clk_ref),
    .rst_n    (rst_n_s),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .pend_div (pend_div),
    .rst_div  (rst_div),
    .aidle_en (aidle_en),
    .err      (div_err)
  );

  clkdiv_core #(.DV_W(DV_W)) u_core (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n_s),
    .pend_div (pend_div),
    .rst_div  (rst_div),
    .aidle_en (aidle_en),
    .idle_req (idle_req),
    .clk_div  (clk_div)
  );

endmodule

// File: tb/regdiv_clkgen_test.sv
`timescale 1ns/1ps
module regdiv_clkgen_test;
  import clkdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] wdata;
  logic [3:0]  we;
  logic        idle_req;
  logic [31:0] rd0, rd1, rd2, rd3;
  logic        ck0, ck1, ck2, ck3;
  logic        er0, er1, er2, er3;
  int          tests = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  regdiv_clkgen #(.ENC(ENC_PLUS1), .DIV_W(7), .DIV_SHIFT(0), .IDLE_BIT(8),
    .LATCH_BIT(9), .MIN_DIV(1), .MAX_DIV(127), .RST_CODE(1)) uut (
    .clk_ref(clk), .rst_n(rst_n), .reg_we(we[0]), .reg_wdata(wdata),
    .reg_rdata(rd0), .idle_req(idle_req), .clk_div(ck0), .div_err(er0));

  regdiv_clkgen #(.ENC(ENC_DIRECT), .DIV_W(5), .DIV_SHIFT(24), .IDLE_BIT(4),
    .LATCH_BIT(5), .LATCH_EN(1'b1), .MIN_DIV(2), .MAX_DIV(31), .RST_CODE(3)) uut_dir (
    .clk_ref(clk), .rst_n(rst_n), .reg_we(we[1]), .reg_wdata(wdata),
    .reg_rdata(rd1), .idle_req(idle_req), .clk_div(ck1), .div_err(er1));

  regdiv_clkgen #(.ENC(ENC_POW2), .DIV_W(3), .DIV_SHIFT(4), .IDLE_BIT(0),
    .LATCH_BIT(1), .MIN_DIV(1), .MAX_DIV(64), .RST_CODE(0)) uut_p2 (
    .clk_ref(clk), .rst_n(rst_n), .reg_we(we[2]), .reg_wdata(wdata),
    .reg_rdata(rd2), .idle_req(idle_req), .clk_div(ck2), .div_err(er2));

  regdiv_clkgen #(.ENC(ENC_TABLE), .DIV_W(4), .DIV_SHIFT(8), .IDLE_BIT(0),
    .LATCH_BIT(1), .IDLE_INV(1'b1), .RST_CODE(0), .TBL_N(16), .TBL_EW(8),
    .DIV_TABLE(128'h0000_0000_0000_0000_0000_0003_1000_0804)) uut_tab (
    .clk_ref(clk), .rst_n(rst_n), .reg_we(we[3]), .reg_wdata(wdata),
    .reg_rdata(rd3), .idle_req(idle_req), .clk_div(ck3), .div_err(er3));

  function automatic logic ck(input int s);
    case (s)
      0: return ck0;
      1: return ck1;
      2: return ck2;
      default: return ck3;
    endcase
  endfunction

  function automatic logic [31:0] rd(input int s);
    case (s)
      0: return rd0;
      1: return rd1;
      2: return rd2;
      default: return rd3;
    endcase
  endfunction

  function automatic logic er(input int s);
    case (s)
      0: return er0;
      1: return er1;
      2: return er2;
      default: return er3;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int s, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    we[s] = 1'b1;
    @(negedge clk);
    we = '0;
  endtask

  // Lengths of one full high phase and the low phase after it.
  task automatic meas(input int s, output int hi, output int lo);
    logic prev;
    bit   found;
    hi = 0;
    lo = 0;
    found = 1'b0;
    cyc();
    prev = ck(s);
    for (int i = 0; i < 400; i++) begin
      cyc();
      if (!prev && ck(s)) begin
        found = 1'b1;
        break;
      end
      prev = ck(s);
    end
    if (found) begin
      hi = 1;
      for (int i = 0; i < 400; i++) begin
        cyc();
        if (ck(s)) hi++;
        else break;
      end
      lo = 1;
      for (int i = 0; i < 400; i++) begin
        cyc();
        if (!ck(s)) lo++;
        else break;
      end
    end
  endtask

  task automatic period_chk(input string tag, input int s, input int ehi, input int elo);
    int hi, lo;
    meas(s, hi, lo);
    meas(s, hi, lo);
    chk({tag, " high phase"}, hi, ehi);
    chk({tag, " low phase"}, lo, elo);
  endtask

  task automatic passthru_chk(input string tag, input int s);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (ck(s) !== 1'b1) bad++;
      @(negedge clk); #1;
      if (ck(s) !== 1'b0) bad++;
    end
    chk({tag, " pass-through mismatches"}, bad, 0);
  endtask

  task automatic parked_chk(input string tag, input int s);
    int highs = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      if (ck(s)) highs++;
      @(negedge clk); #1;
      if (ck(s)) highs++;
    end
    chk({tag, " high samples while parked"}, highs, 0);
  endtask

  task automatic t_reset();
    chk("R12 err0", er(0), 0);
    chk("R12 err1", er(1), 0);
    chk("R12 err2", er(2), 0);
    chk("R12 err3", er(3), 0);
    chk("R12 R11 rdata0", rd(0), 32'h0000_0001);
    chk("R12 R11 rdata1", rd(1), 32'h0300_0000);
    chk("R12 rdata3", rd(3), 0);
    period_chk("R12 R7 uut div2", 0, 1, 1);
    period_chk("R12 R2 uut_dir div3", 1, 1, 2);
    period_chk("R12 R4 uut_tab div4", 3, 2, 2);
  endtask

  task automatic t_plus1();
    wr(0, 32'd4);
    period_chk("R1 R7 code4 div5", 0, 2, 3);
    wr(0, 32'd7);
    period_chk("R1 R7 code7 div8", 0, 4, 4);
    wr(0, 32'd0);
    repeat (20) cyc();
    passthru_chk("R1 R7 code0", 0);
  endtask

  task automatic t_bounds();
    wr(0, 32'd127);
    cyc();
    chk("R5 R6 err after code127", er(0), 1);
    chk("R6 rdata kept", rd(0), 0);
    passthru_chk("R6 divisor kept", 0);
    wr(0, 32'd5);
    cyc();
    chk("R6 err sticky", er(0), 1);
    chk("R11 rdata code5", rd(0), 5);
    period_chk("R1 code5 div6", 0, 3, 3);
  endtask

  task automatic t_change();
    int hi, lo, run, bad, nruns;
    logic [47:0] smp;
    logic cur;
    bit first;
    wr(0, 32'd7);
    meas(0, hi, lo);
    meas(0, hi, lo);
    cyc();
    wr(0, 32'd2);
    for (int i = 0; i < 48; i++) begin
      cyc();
      smp[i] = ck(0);
    end
    run = 1; bad = 0; nruns = 0; first = 1'b1; cur = smp[0];
    for (int i = 1; i < 48; i++) begin
      if (smp[i] == cur) begin
        run++;
      end else begin
        if (!first) begin
          nruns++;
          if (cur && !(run == 4 || run == 1)) bad++;
          if (!cur && !(run == 4 || run == 2)) bad++;
        end
        first = 1'b0;
        cur = smp[i];
        run = 1;
      end
    end
    chk("R8 shortened phases", bad, 0);
    chk("R8 enough phases seen", (nruns >= 10), 1);
    period_chk("R8 new div3", 0, 1, 2);
  endtask

  task automatic t_direct();
    wr(1, 32'h0600_0000);
    cyc();
    chk("R9 R11 staged readback", rd(1), 32'h0600_0000);
    period_chk("R9 not committed", 1, 1, 2);
    wr(1, 32'h0600_0020);
    cyc();
    chk("R11 commit bit reads zero", rd(1), 32'h0600_0000);
    period_chk("R2 R9 committed div6", 1, 3, 3);
    wr(1, 32'h0000_0020);
    cyc();
    chk("R2 code0 rejected", er(1), 1);
    chk("R2 R6 readback kept", rd(1), 32'h0600_0000);
    wr(1, 32'h0100_0020);
    cyc();
    chk("R5 code1 below min readback", rd(1), 32'h0600_0000);
    period_chk("R5 R6 divisor kept", 1, 3, 3);
  endtask

  task automatic t_pow2();
    passthru_chk("R3 R7 code0 div1", 2);
    wr(2, 32'h20);
    period_chk("R3 code2 div4", 2, 2, 2);
    wr(2, 32'h30);
    period_chk("R3 code3 div8", 2, 4, 4);
    chk("R3 no err yet", er(2), 0);
    wr(2, 32'h70);
    cyc();
    chk("R3 R5 code7 over max", er(2), 1);
    chk("R6 R11 readback kept", rd(2), 32'h30);
    wr(2, 32'h60);
    period_chk("R3 code6 div64", 2, 32, 32);
  endtask

  task automatic t_table();
    wr(3, 32'h300);
    period_chk("R4 code3 div16", 3, 8, 8);
    chk("R4 no err yet", er(3), 0);
    wr(3, 32'h200);
    cyc();
    chk("R4 zero entry rejected", er(3), 1);
    chk("R4 R6 readback kept", rd(3), 32'h300);
    wr(3, 32'h400);
    period_chk("R4 R7 code4 odd div3", 3, 1, 2);
  endtask

  task automatic t_idle();
    int hi, lo;
    wr(0, 32'h103);
    period_chk("R10 uut div4 running", 0, 2, 2);
    idle_req = 1'b1;
    repeat (12) cyc();
    parked_chk("R10 uut enabled", 0);
    parked_chk("R10 uut_tab inverted polarity", 3);
    meas(1, hi, lo);
    chk("R10 uut_dir not enabled high", hi, 3);
    chk("R10 uut_dir not enabled low", lo, 3);
    wr(3, 32'h401);
    period_chk("R10 uut_tab disabled", 3, 1, 2);
    idle_req = 1'b0;
    period_chk("R10 uut resumes", 0, 2, 2);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wdata = '0;
    we = '0;
    idle_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plus1();
    t_bounds();
    t_change();
    t_direct();
    t_pow2();
    t_table();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule